// File: doc/BRIEF.md
# Two-Level Cache Tag Latency Model

This block models a private two-level cache hierarchy placed in front of main memory. It holds tags only and no data. Each accepted line request is looked up in a small first-level tag store and, when that misses, in a larger second-level tag store. The block then reports how many cycles the hierarchy would need to service the request. A request that misses both levels goes to main memory. Main memory always answers after a fixed cost, and that cost already includes the directory lookup.

Both levels fill the requested line on a miss. Each level replaces the least recently used way of the addressed set. A line pushed out of the smaller level can therefore still be found in the larger one. Per-level counters record hits, misses, misses with read-shared intent, and cycles spent. A level's cycle count includes the time spent below it. A further counter records one directory add-sharer message for every fetch that reaches memory.

A request is a byte address plus a read-shared intent bit, passed over a valid/ready handshake. Only one request is in flight at a time. The answer is a one-cycle done pulse that carries the latency.

Top module: `cache2_latency_model`

## Requirements
- R1: After a synchronous reset both tag stores hold no valid line, every counter reads zero, `req_ready` is 1 and `resp_done` is 0.
- R2: A request that misses both levels returns a latency of 112 cycles (2 + 10 + 100).
- R3: A request whose line is present in the first level returns a latency of 2 cycles.
- R4: A request that misses the first level but hits the second returns a latency of 12 cycles.
- R5: Addresses 256 bytes apart (64-byte line × 4 sets) share a first-level set. With 2 ways, a third such line evicts one of the first two.
- R6: Within a set, the victim is the least recently used way, and a hit counts as a use.
- R7: A line evicted from the first level still hits in the second level (8 ways, 128 sets, 128-byte lines) if the second level has not evicted it.
- R8: The first-level counters work as follows. Hits count first-level hits. Misses count all first-level misses. Load misses count only the misses whose request had `req_shared`=1. Ticks accumulate the full latency of every request.
- R9: The second-level counters count only requests that missed the first level. Their ticks accumulate each such request's latency minus the first-level cost (10 or 110).
- R10: Each request that reaches main memory adds 100 to `mem_ticks` and 1 to `dir_add_sharer`.
- R11: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 during the following cycle. On the second rising edge after acceptance, `resp_done` is raised for exactly one cycle, carrying the latency on `resp_lat`, and `req_ready` returns to 1 at that same edge.
- R12: Address bits below the line offset are ignored: any byte in a resident 64-byte line hits in the first level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the request |
| req_shared | input | 1 | 1 = read-shared intent |
| resp_done | output | 1 | One-cycle pulse: latency valid |
| resp_lat | output | 16 | Service latency in cycles |
| l1_hits | output | 32 | First-level hit count |
| l1_misses | output | 32 | First-level miss count |
| l1_load_misses | output | 32 | First-level misses with shared intent |
| l1_ticks | output | 32 | Cumulative cycles seen at first level |
| l2_hits | output | 32 | Second-level hit count |
| l2_misses | output | 32 | Second-level miss count |
| l2_load_misses | output | 32 | Second-level misses with shared intent |
| l2_ticks | output | 32 | Cumulative cycles seen at second level |
| mem_ticks | output | 32 | Cumulative main-memory cycles |
| dir_add_sharer | output | 32 | Directory add-sharer message count |

## Verification
The properties assume that requests arrive only through the handshake. While `req_ready` is low, a held `req_valid` has no effect. They also assume the counters never wrap within a run.

The directed stimulus raises `req_valid` for a single cycle per request and waits for the done pulse before sending the next one. It issues only a few dozen requests, so every counter stays far below its wrap point. The address sets are chosen so that second-level sets never fill, which keeps the first-level replacement order as the only source of eviction.

// File: rtl/cache2_pkg.sv
package cache2_pkg;

  // Set index: drop the line offset, keep idx_w bits.
  function automatic logic [63:0] line_index(input logic [63:0] addr,
                                             input int unsigned off_w,
                                             input int unsigned idx_w);
    return (addr >> off_w) & ((64'd1 << idx_w) - 64'd1);
  endfunction

  // Tag: everything above offset and index.
  function automatic logic [63:0] line_tag(input logic [63:0] addr,
                                           input int unsigned low_w);
    return addr >> low_w;
  endfunction

  // Total service time for a request, by which level serviced it.
  function automatic int unsigned service_cost(input logic hit1,
                                               input logic hit2,
                                               input int unsigned c1,
                                               input int unsigned c2,
                                               input int unsigned cm);
    if (hit1)      return c1;
    else if (hit2) return c1 + c2;
    else           return c1 + c2 + cm;
  endfunction

endpackage

// File: rtl/cache2_tag_level.sv
module cache2_tag_level #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int LINE_B = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              update_en,
  output logic              hit
);
  localparam int OFF_W = $clog2(LINE_B);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];  // 0 = most recently used

  logic [IDX_W-1:0] set_i;
  logic [TAG_W-1:0] tag_i;
  logic [WAYS-1:0]  match_vec;
  logic [WAY_W-1:0] hit_way, victim_way, sel_way;
  logic             have_free;

  always_comb begin
    set_i      = IDX_W'(cache2_pkg::line_index(64'(addr), OFF_W, IDX_W));
    tag_i      = TAG_W'(cache2_pkg::line_tag(64'(addr), OFF_W + IDX_W));
    match_vec  = '0;
    hit_way    = '0;
    victim_way = '0;
    have_free  = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      match_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[set_i][w]) begin
        victim_way = WAY_W'(w);
        have_free  = 1'b1;
      end
    end
    if (!have_free) begin
      for (int w = 0; w < WAYS; w++) begin
        if (age_q[set_i][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
      end
    end
    sel_way = (|match_vec) ? hit_way : victim_way;
  end

  assign hit = |match_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          age_q[s][w]   <= WAY_W'(w);
        end
      end
    end else if (update_en) begin
      valid_q[set_i][sel_way] <= 1'b1;
      tag_q[set_i][sel_way]   <= tag_i;
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way)
          age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < age_q[set_i][sel_way])
          age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  // R5: a tag is never held twice in one set
  p_unique_tag_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R12: a line just touched or filled is found again at the same address
  p_fill_hits_r12: assert property (@(posedge clk) disable iff (rst)
    update_en ##1 $stable(addr) |-> hit);

endmodule

// File: rtl/cache2_level_stats.sv
module cache2_level_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             event_en,
  input  logic             hit,
  input  logic             shared,
  input  logic [CNT_W-1:0] cost_add,
  output logic [CNT_W-1:0] hits,
  output logic [CNT_W-1:0] misses,
  output logic [CNT_W-1:0] load_misses,
  output logic [CNT_W-1:0] ticks
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hits        <= '0;
      misses      <= '0;
      load_misses <= '0;
      ticks       <= '0;
    end else if (event_en) begin
      ticks <= ticks + cost_add;
      if (hit) begin
        hits <= hits + 1'b1;
      end else begin
        misses <= misses + 1'b1;
        if (shared) load_misses <= load_misses + 1'b1;
      end
    end
  end

  // R8: a counted event moves exactly one of hits/misses
  p_one_class_r8: assert property (@(posedge clk) disable iff (rst)
    event_en |=> ((hits - $past(hits)) + (misses - $past(misses))) == CNT_W'(1));

endmodule

// File: rtl/cache2_latency_model.sv
module cache2_latency_model #(
  parameter int ADDR_W   = 32,
  parameter int L1_SETS  = 4,
  parameter int L1_WAYS  = 2,
  parameter int L1_LINE  = 64,
  parameter int L1_COST  = 2,
  parameter int L2_SETS  = 128,
  parameter int L2_WAYS  = 8,
  parameter int L2_LINE  = 128,
  parameter int L2_COST  = 10,
  parameter int MEM_COST = 100,
  parameter int LAT_W    = 16,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_shared,
  output logic              resp_done,
  output logic [LAT_W-1:0]  resp_lat,
  output logic [CNT_W-1:0]  l1_hits,
  output logic [CNT_W-1:0]  l1_misses,
  output logic [CNT_W-1:0]  l1_load_misses,
  output logic [CNT_W-1:0]  l1_ticks,
  output logic [CNT_W-1:0]  l2_hits,
  output logic [CNT_W-1:0]  l2_misses,
  output logic [CNT_W-1:0]  l2_load_misses,
  output logic [CNT_W-1:0]  l2_ticks,
  output logic [CNT_W-1:0]  mem_ticks,
  output logic [CNT_W-1:0]  dir_add_sharer
);
  localparam int FULL_MISS = L1_COST + L2_COST + MEM_COST;

  logic              busy_q, shared_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LAT_W-1:0]  lat_q;

  // Named internal events
  logic              accept;
  logic              l1_hit, l2_hit;
  logic              l1_update, l2_update, mem_fetch;
  logic [CNT_W-1:0]  total_cost, below_l1_cost;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign l1_update = busy_q;
  assign l2_update = busy_q && !l1_hit;
  assign mem_fetch = busy_q && !l1_hit && !l2_hit;

  assign total_cost    = CNT_W'(cache2_pkg::service_cost(l1_hit, l2_hit,
                           L1_COST, L2_COST, MEM_COST));
  assign below_l1_cost = total_cost - CNT_W'(L1_COST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      lat_q    <= '0;
      shared_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      done_q <= busy_q;
      if (busy_q) begin
        busy_q <= 1'b0;
        lat_q  <= LAT_W'(total_cost);
      end else if (accept) begin
        busy_q   <= 1'b1;
        addr_q   <= req_addr;
        shared_q <= req_shared;
      end
    end
  end

  assign resp_done = done_q;
  assign resp_lat  = lat_q;

  cache2_tag_level #(.ADDR_W(ADDR_W), .SETS(L1_SETS), .WAYS(L1_WAYS),
                     .LINE_B(L1_LINE)) u_l1_tags (
    .clk(clk), .rst(rst), .addr(addr_q), .update_en(l1_update), .hit(l1_hit));

  cache2_tag_level #(.ADDR_W(ADDR_W), .SETS(L2_SETS), .WAYS(L2_WAYS),
                     .LINE_B(L2_LINE)) u_l2_tags (
    .clk(clk), .rst(rst), .addr(addr_q), .update_en(l2_update), .hit(l2_hit));

  cache2_level_stats #(.CNT_W(CNT_W)) u_l1_stats (
    .clk(clk), .rst(rst), .event_en(l1_update), .hit(l1_hit),
    .shared(shared_q), .cost_add(total_cost),
    .hits(l1_hits), .misses(l1_misses), .load_misses(l1_load_misses),
    .ticks(l1_ticks));

  cache2_level_stats #(.CNT_W(CNT_W)) u_l2_stats (
    .clk(clk), .rst(rst), .event_en(l2_update), .hit(l2_hit),
    .shared(shared_q), .cost_add(below_l1_cost),
    .hits(l2_hits), .misses(l2_misses), .load_misses(l2_load_misses),
    .ticks(l2_ticks));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ticks      <= '0;
      dir_add_sharer <= '0;
    end else if (mem_fetch) begin
      mem_ticks      <= mem_ticks + CNT_W'(MEM_COST);
      dir_add_sharer <= dir_add_sharer + 1'b1;
    end
  end

  // R11: no second acceptance while a request is in flight
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R11: answer two edges after acceptance
  p_resp_timing_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ##2 resp_done);

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    resp_done |=> !resp_done);

  // R2: only the three service times can appear
  p_lat_legal_r2: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> (resp_lat == LAT_W'(L1_COST) ||
                   resp_lat == LAT_W'(L1_COST + L2_COST) ||
                   resp_lat == LAT_W'(FULL_MISS)));

  // R3: a first-level latency goes with a first-level hit count step
  p_l1_hit_counted_r3: assert property (@(posedge clk) disable iff (rst)
    (resp_done && resp_lat == LAT_W'(L1_COST)) |-> l1_hits == $past(l1_hits) + 1'b1);

  // R10: a directory message goes with every full miss and nothing else
  p_dir_tracks_mem_r10: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> (dir_add_sharer - $past(dir_add_sharer)) ==
                  ((resp_lat == LAT_W'(FULL_MISS)) ? CNT_W'(1) : CNT_W'(0)));

endmodule

// File: tb/cache2_latency_model_bench.sv
module cache2_latency_model_bench;
  localparam int CLK_P = 10;
  localparam logic [31:0] A_BASE = 32'd100000000;
  localparam logic [31:0] B_BASE = A_BASE + 32'd128;
  localparam logic [31:0] C_BASE = A_BASE + 32'h0010_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_shared = 1'b0;
  logic        resp_done;
  logic [15:0] resp_lat;
  logic [31:0] l1_hits, l1_misses, l1_load_misses, l1_ticks;
  logic [31:0] l2_hits, l2_misses, l2_load_misses, l2_ticks;
  logic [31:0] mem_ticks, dir_add_sharer;

  int checks = 0;
  int errors = 0;
  // expected counters, built from requirement arithmetic
  int e_l1h = 0, e_l1m = 0, e_l1l = 0, e_l1t = 0;
  int e_l2h = 0, e_l2m = 0, e_l2l = 0, e_l2t = 0;
  int e_mt = 0, e_dir = 0;

  always #(CLK_P/2) clk = ~clk;

  cache2_latency_model u_cache2_latency_model (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_shared(req_shared), .resp_done(resp_done),
    .resp_lat(resp_lat), .l1_hits(l1_hits), .l1_misses(l1_misses),
    .l1_load_misses(l1_load_misses), .l1_ticks(l1_ticks),
    .l2_hits(l2_hits), .l2_misses(l2_misses),
    .l2_load_misses(l2_load_misses), .l2_ticks(l2_ticks),
    .mem_ticks(mem_ticks), .dir_add_sharer(dir_add_sharer));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One request; expected latency from the requirement table.
  task automatic issue(input logic [31:0] addr, input logic sh,
                       input int exp_lat, input string tag);
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = addr;
    req_shared = sh;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 ready low while busy", req_ready, 0);
    @(negedge clk);
    check("R11 done pulse", resp_done, 1);
    check("R11 ready back", req_ready, 1);
    check(tag, resp_lat, exp_lat);
    @(negedge clk);
    check("R11 done one cycle", resp_done, 0);
    if (exp_lat == 2) begin
      e_l1h++; e_l1t += 2;
    end else begin
      e_l1m++; if (sh) e_l1l++; e_l1t += exp_lat;
      if (exp_lat == 12) begin
        e_l2h++; e_l2t += 10;
      end else begin
        e_l2m++; if (sh) e_l2l++; e_l2t += 110;
        e_mt += 100; e_dir++;
      end
    end
  endtask

  task automatic check_counters(input string tag);
    check({tag, " l1_hits R8"},        l1_hits,        e_l1h);
    check({tag, " l1_misses R8"},      l1_misses,      e_l1m);
    check({tag, " l1_load_misses R8"}, l1_load_misses, e_l1l);
    check({tag, " l1_ticks R8"},       l1_ticks,       e_l1t);
    check({tag, " l2_hits R9"},        l2_hits,        e_l2h);
    check({tag, " l2_misses R9"},      l2_misses,      e_l2m);
    check({tag, " l2_load_misses R9"}, l2_load_misses, e_l2l);
    check({tag, " l2_ticks R9"},       l2_ticks,       e_l2t);
    check({tag, " mem_ticks R10"},     mem_ticks,      e_mt);
    check({tag, " dir_add_sharer R10"}, dir_add_sharer, e_dir);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", req_ready, 1);
    check("R1 done after reset", resp_done, 0);
    check_counters("R1 reset");
  endtask

  // Conflicting lines in first-level set 0
  task automatic t_conflict_chain;
    issue(A_BASE,          1'b1, 112, "R2 cold miss");
    issue(A_BASE,          1'b1, 2,   "R3 repeat hit");
    issue(A_BASE + 32'd256, 1'b1, 112, "R5 same set second way");
    issue(A_BASE + 32'd512, 1'b1, 112, "R5 third line evicts");
    issue(A_BASE,          1'b1, 12,  "R4 R7 evicted line hits L2");
    check("R8 l1_ticks total", l1_ticks, 350);
    check("R9 l2_ticks total", l2_ticks, 340);
    check("R10 mem_ticks total", mem_ticks, 300);
    check("R10 dir messages", dir_add_sharer, 3);
    check_counters("chain");
  endtask

  task automatic t_offset;
    issue(A_BASE + 32'd63, 1'b1, 2,  "R12 last byte of line hits");
    issue(A_BASE + 32'd17, 1'b1, 2,  "R12 inner byte hits");
  endtask

  // Hit refreshes recency in first-level set 2
  task automatic t_lru_touch;
    issue(B_BASE,           1'b1, 112, "R6 fill way");
    issue(B_BASE + 32'd256, 1'b1, 112, "R6 fill other way");
    issue(B_BASE,           1'b1, 2,   "R6 touch older line");
    issue(B_BASE + 32'd512, 1'b1, 112, "R6 evicts untouched line");
    issue(B_BASE,           1'b1, 2,   "R6 touched line survives");
    issue(B_BASE + 32'd256, 1'b1, 12,  "R6 victim back from L2");
    check_counters("lru");
  endtask

  task automatic t_non_shared;
    int lm_before;
    lm_before = l1_load_misses;
    issue(C_BASE, 1'b0, 112, "R8 non-shared miss latency");
    check("R8 load miss unchanged", l1_load_misses, lm_before);
    check_counters("intent");
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_conflict_chain();
    t_offset();
    t_lru_touch();
    t_non_shared();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule